// File: doc/BRIEF.md
# Sleep entry and wakeup controller

This block sequences a chip into light or deep sleep and back out again. Software sets up a wakeup-source enable mask, a sleep-reject mask, a light/deep choice and a timer duration, then pulses start. On the first cycle after a start is accepted, the block checks whether an enabled reject source is already active. If one is, the sleep is refused. Otherwise the block drops its oscillator, crystal and PLL power requests and sleeps until an enabled, qualified wake event arrives.

On wakeup the block waits a fixed number of slow-clock ticks. It then raises the internal-oscillator, crystal and PLL requests one after another, holding each for its own programmed wait, counted in fast-clock cycles. When the sequence ends, the block reports one of three outcomes:

- woke (a light sleep ended normally);
- rejected (the sleep was refused);
- deep reset (a deep sleep ended; a one-cycle CPU reset pulse is also issued).

The outcome and a latched wake-cause bitmask stay on the outputs until the next start is accepted. The slow clock is a tick enable, one cycle wide, on the fast clock `clk`.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`, `sleeping`, `done` and `cpu_rst` are 0, `outcome` is 0 (none) and `wake_cause` is 0. `osc_req`, `xtal_req` and `pll_req` are 1.
- R2: GPIO (bit 2) and SDIO (bit 4) can refuse a sleep. If either is enabled in `reject_en` and active in `wake_evt` in the cycle after start is accepted, the block never sleeps. It returns to idle with a `done` pulse, `outcome` = 2 (rejected) and `wake_cause` = 0.
- R3: Reject enables on any bit other than 2 and 4 have no effect.
- R4: While sleeping, the first cycle in which any enabled source is active ends the sleep. All such active bits are latched into `wake_cause`. The bit positions are: EXT0=0, EXT1=1, GPIO=2, TIMER=3, SDIO=4, MAC=5, UART0=6, UART1=7, TOUCH=8, ULP=9, BT=10.
- R5: In deep sleep the sources GPIO, SDIO, MAC, UART0, UART1 and BT (bits 2, 4, 5, 6, 7, 10) are ignored. In light sleep they are honoured.
- R6: With TIMER enabled, the sleep ends after exactly max(target, 128) slow-clock ticks, counted from sleep entry. `wake_cause` then shows bit 3.
- R7: After a wake event, all three power requests stay low for exactly 7 slow-clock ticks before `osc_req` rises.
- R8: The requests rise in a fixed order: `osc_req`, then `xtal_req`, then `pll_req`. Each stage (osc only; osc+xtal; all three) lasts its programmed wait + 1 fast-clock cycles before the next request rises or the sequence ends.
- R9: An oscillator wait of 0 selects a default of 20, so that stage lasts 21 cycles.
- R10: A light sleep ends with `outcome` = 1 (woke) and no CPU reset. A deep sleep ends with `outcome` = 3 (deep reset) and a one-cycle `cpu_rst` pulse coinciding with `done`.
- R11: A start pulse while `busy` is ignored. The configuration captured at the accepted start stays in use.
- R12: `outcome` and `wake_cause` hold their values after `done` until the next accepted start, which clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle slow-clock tick enable |
| start | input | 1 | Request a sleep (accepted only when idle) |
| deep_sel | input | 1 | 1 = deep sleep, 0 = light sleep |
| wake_en | input | 11 | Wakeup source enable mask |
| reject_en | input | 11 | Sleep-reject enable mask (bits 2 and 4 effective) |
| timer_target | input | 32 | Timer sleep duration in slow ticks |
| wait_osc | input | 8 | Oscillator stage wait, fast cycles (0 = default) |
| wait_xtal | input | 8 | Crystal stage wait, fast cycles |
| wait_pll | input | 8 | PLL stage wait, fast cycles |
| wake_evt | input | 11 | Live source activity; bit 3 is an external alarm ORed with the internal timer match |
| busy | output | 1 | Not idle |
| sleeping | output | 1 | Asleep, waiting for a wake event |
| done | output | 1 | One-cycle pulse when an outcome is posted |
| outcome | output | 2 | 0 none, 1 woke, 2 rejected, 3 deep reset |
| wake_cause | output | 11 | Enabled sources that ended the sleep |
| cpu_rst | output | 1 | One-cycle CPU reset pulse after deep sleep |
| osc_req | output | 1 | Internal oscillator power request |
| xtal_req | output | 1 | Crystal power request |
| pll_req | output | 1 | PLL power request |

## Verification
The assertions take for granted that `slow_tick` is a single-cycle pulse that never fires on two consecutive cycles. They also assume that any source a test relies on for a reject is already steady when the start pulse is accepted. The stimulus spaces ticks four fast cycles apart. It sets every event level before pulsing start, or raises it only after `sleeping` is seen. Each event is held until `done`, so no wake edge or reject sample falls between two clock phases.

// File: rtl/slpw_pkg.sv
package slpw_pkg;

   localparam int SRC_N     = 11;
   localparam int TIMER_POS = 3;

   // sources honoured only while the chip stays in light sleep
   localparam logic [SRC_N-1:0] LIGHT_ONLY = 11'h4F4;
   // sources that may refuse a sleep request
   localparam logic [SRC_N-1:0] REJECT_OK  = 11'h014;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SLEEP,
      ST_DELAY,
      ST_WOSC,
      ST_WXTAL,
      ST_WPLL
   } slp_state_t;

   typedef enum logic [1:0] {
      OUT_NONE   = 2'd0,
      OUT_WOKE   = 2'd1,
      OUT_REJECT = 2'd2,
      OUT_DEEP   = 2'd3
   } outcome_t;

endpackage

// File: rtl/slpw_src_filter.sv
module slpw_src_filter
   import slpw_pkg::*;
(
   input  logic [SRC_N-1:0] en_q,
   input  logic [SRC_N-1:0] rej_q,
   input  logic             deep_q,
   input  logic [SRC_N-1:0] evt,
   input  logic             timer_hit,
   output logic [SRC_N-1:0] trig,
   output logic             reject_hit
);

   logic [SRC_N-1:0] rej_bits;

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i == TIMER_POS) begin : g_timer
         assign trig[i] = en_q[i] & (timer_hit | evt[i]);
      end else if (LIGHT_ONLY[i]) begin : g_light
         assign trig[i] = en_q[i] & evt[i] & ~deep_q;
      end else begin : g_any
         assign trig[i] = en_q[i] & evt[i];
      end

      if (REJECT_OK[i]) begin : g_rej
         assign rej_bits[i] = rej_q[i] & evt[i];
      end else begin : g_norej
         assign rej_bits[i] = 1'b0;
      end
   end

   assign reject_hit = |rej_bits;

endmodule

// File: rtl/slpw_timer.sv
module slpw_timer #(
   parameter int TMR_W     = 32,
   parameter int MIN_SLEEP = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             arm,
   input  logic [TMR_W-1:0] tgt,
   input  logic             active,
   output logic             hit
);

   localparam logic [TMR_W-1:0] MIN_V = TMR_W'(MIN_SLEEP);

   logic [TMR_W-1:0] cnt;
   logic [TMR_W-1:0] cnt_nx;
   logic [TMR_W-1:0] deadline;
   logic [TMR_W-1:0] eff;
   logic [TMR_W-1:0] elapsed;

   assign cnt_nx = cnt + TMR_W'(tick);
   assign eff    = (tgt < MIN_V) ? MIN_V : tgt;
   assign hit    = active && (cnt == deadline);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         deadline <= '0;
      end else begin
         cnt <= cnt_nx;
         if (arm) deadline <= cnt_nx + eff;
      end
   end

   // ticks since the sleep was armed, used only by the check below
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   elapsed <= '0;
      else if (arm)                 elapsed <= '0;
      else if (active && tick)      elapsed <= elapsed + 1'b1;
   end

   AST_TIMER_MIN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (elapsed >= MIN_V)); // R6

endmodule

// File: rtl/slpw_seq.sv
module slpw_seq
   import slpw_pkg::*;
#(
   parameter int TMR_W     = 32,
   parameter int WAIT_W    = 8,
   parameter int WAKE_DLY  = 7,
   parameter int DEF_OSC   = 20,
   localparam int DLY_W    = $clog2(WAKE_DLY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              deep_in,
   input  logic [SRC_N-1:0]  wen_in,
   input  logic [SRC_N-1:0]  rej_in,
   input  logic [TMR_W-1:0]  tgt_in,
   input  logic [WAIT_W-1:0] wosc_in,
   input  logic [WAIT_W-1:0] wxtal_in,
   input  logic [WAIT_W-1:0] wpll_in,
   input  logic [SRC_N-1:0]  trig,
   input  logic              reject_hit,
   output logic              deep_q,
   output logic [SRC_N-1:0]  wen_q,
   output logic [SRC_N-1:0]  rej_q,
   output logic [TMR_W-1:0]  tgt_q,
   output logic              arm,
   output slp_state_t        state,
   output logic              done_o,
   output outcome_t          outcome_o,
   output logic [SRC_N-1:0]  cause_o,
   output logic              cpu_rst_o,
   output logic              osc_o,
   output logic              xtal_o,
   output logic              pll_o
);

   logic [WAIT_W-1:0] wosc_q, wxtal_q, wpll_q;
   logic [WAIT_W-1:0] wosc_eff;
   logic [WAIT_W-1:0] scnt;
   logic [DLY_W-1:0]  dcnt;

   assign wosc_eff = (wosc_q == '0) ? WAIT_W'(DEF_OSC) : wosc_q;
   assign arm      = (state == ST_CHECK) && !reject_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         deep_q    <= 1'b0;
         wen_q     <= '0;
         rej_q     <= '0;
         tgt_q     <= '0;
         wosc_q    <= '0;
         wxtal_q   <= '0;
         wpll_q    <= '0;
         scnt      <= '0;
         dcnt      <= '0;
         done_o    <= 1'b0;
         outcome_o <= OUT_NONE;
         cause_o   <= '0;
         cpu_rst_o <= 1'b0;
      end else begin
         done_o    <= 1'b0;
         cpu_rst_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  deep_q    <= deep_in;
                  wen_q     <= wen_in;
                  rej_q     <= rej_in;
                  tgt_q     <= tgt_in;
                  wosc_q    <= wosc_in;
                  wxtal_q   <= wxtal_in;
                  wpll_q    <= wpll_in;
                  outcome_o <= OUT_NONE;
                  cause_o   <= '0;
                  state     <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (reject_hit) begin
                  outcome_o <= OUT_REJECT;
                  done_o    <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  state <= ST_SLEEP;
               end
            end
            ST_SLEEP: begin
               if (|trig) begin
                  cause_o <= trig;
                  dcnt    <= DLY_W'(WAKE_DLY);
                  state   <= ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (tick) begin
                  if (dcnt == DLY_W'(1)) begin
                     scnt  <= wosc_eff;
                     state <= ST_WOSC;
                  end else begin
                     dcnt <= dcnt - 1'b1;
                  end
               end
            end
            ST_WOSC: begin
               if (scnt == '0) begin
                  scnt  <= wxtal_q;
                  state <= ST_WXTAL;
               end else begin
                  scnt <= scnt - 1'b1;
               end
            end
            ST_WXTAL: begin
               if (scnt == '0) begin
                  scnt  <= wpll_q;
                  state <= ST_WPLL;
               end else begin
                  scnt <= scnt - 1'b1;
               end
            end
            ST_WPLL: begin
               if (scnt == '0) begin
                  done_o    <= 1'b1;
                  outcome_o <= deep_q ? OUT_DEEP : OUT_WOKE;
                  cpu_rst_o <= deep_q;
                  state     <= ST_IDLE;
               end else begin
                  scnt <= scnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      osc_o  = 1'b1;
      xtal_o = 1'b1;
      pll_o  = 1'b1;
      unique case (state)
         ST_SLEEP, ST_DELAY: begin
            osc_o = 1'b0; xtal_o = 1'b0; pll_o = 1'b0;
         end
         ST_WOSC:  begin xtal_o = 1'b0; pll_o = 1'b0; end
         ST_WXTAL: begin pll_o = 1'b0; end
         default: ;
      endcase
   end

   AST_CHECK_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK) |-> ($past(state) == ST_IDLE)); // R11

   AST_REJECT_SKIPS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && reject_hit) |=> (state == ST_IDLE && outcome_o == OUT_REJECT)); // R2

   AST_RESET_ONLY_AFTER_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |-> (outcome_o == OUT_DEEP && done_o)); // R10

   AST_PLL_AFTER_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_o) |-> $past(xtal_o)); // R8

   AST_XTAL_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xtal_o) |-> $past(osc_o)); // R8

   AST_REQS_LOW_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DELAY && $past(state) == ST_SLEEP) |-> !osc_o); // R7

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
   import slpw_pkg::*;
#(
   parameter int TMR_W     = 32,
   parameter int WAIT_W    = 8,
   parameter int MIN_SLEEP = 128,
   parameter int WAKE_DLY  = 7,
   parameter int DEF_OSC   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              start,
   input  logic              deep_sel,
   input  logic [10:0]       wake_en,
   input  logic [10:0]       reject_en,
   input  logic [TMR_W-1:0]  timer_target,
   input  logic [WAIT_W-1:0] wait_osc,
   input  logic [WAIT_W-1:0] wait_xtal,
   input  logic [WAIT_W-1:0] wait_pll,
   input  logic [10:0]       wake_evt,
   output logic              busy,
   output logic              sleeping,
   output logic              done,
   output logic [1:0]        outcome,
   output logic [10:0]       wake_cause,
   output logic              cpu_rst,
   output logic              osc_req,
   output logic              xtal_req,
   output logic              pll_req
);

   if (WAIT_W < 1) begin : g_bad_wait
      $error("WAIT_W must be at least 1");
   end
   if (WAKE_DLY < 1) begin : g_bad_dly
      $error("WAKE_DLY must be at least 1");
   end
   if (DEF_OSC < 1 || DEF_OSC >= (1 << WAIT_W)) begin : g_bad_def
      $error("DEF_OSC must be nonzero and fit in WAIT_W bits");
   end
   if (TMR_W < 2 || TMR_W > 32 || MIN_SLEEP < 1 || MIN_SLEEP >= (1 << (TMR_W - 1))) begin : g_bad_tmr
      $error("MIN_SLEEP must be nonzero and fit in TMR_W-1 bits");
   end

   logic             deep_q;
   logic [SRC_N-1:0] wen_q, rej_q, trig;
   logic [TMR_W-1:0] tgt_q;
   logic             arm, timer_hit, reject_hit;
   slp_state_t       state;
   outcome_t         outcome_e;

   slpw_seq #(
      .TMR_W(TMR_W), .WAIT_W(WAIT_W), .WAKE_DLY(WAKE_DLY), .DEF_OSC(DEF_OSC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .start(start),
      .deep_in(deep_sel), .wen_in(wake_en), .rej_in(reject_en),
      .tgt_in(timer_target), .wosc_in(wait_osc), .wxtal_in(wait_xtal),
      .wpll_in(wait_pll), .trig(trig), .reject_hit(reject_hit),
      .deep_q(deep_q), .wen_q(wen_q), .rej_q(rej_q), .tgt_q(tgt_q),
      .arm(arm), .state(state), .done_o(done), .outcome_o(outcome_e),
      .cause_o(wake_cause), .cpu_rst_o(cpu_rst),
      .osc_o(osc_req), .xtal_o(xtal_req), .pll_o(pll_req)
   );

   slpw_timer #(.TMR_W(TMR_W), .MIN_SLEEP(MIN_SLEEP)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .arm(arm), .tgt(tgt_q),
      .active(state == ST_SLEEP), .hit(timer_hit)
   );

   slpw_src_filter u_filt (
      .en_q(wen_q), .rej_q(rej_q), .deep_q(deep_q), .evt(wake_evt),
      .timer_hit(timer_hit), .trig(trig), .reject_hit(reject_hit)
   );

   assign outcome  = outcome_e;
   assign busy     = (state != ST_IDLE);
   assign sleeping = (state == ST_SLEEP);

   AST_DEEP_IGNORES_LIGHT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst |-> ((wake_cause & LIGHT_ONLY) == '0)); // R5

   AST_CAUSE_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && !$past(start)) |-> $stable(wake_cause)); // R12

   AST_REJECT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && outcome == 2'd2) |-> (wake_cause == '0)); // R2

endmodule

// File: tb/slp_wake_ctrl_tb.sv
module slp_wake_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        start = 1'b0;
   logic        deep_sel = 1'b0;
   logic [10:0] wake_en = '0;
   logic [10:0] reject_en = '0;
   logic [31:0] timer_target = '0;
   logic [7:0]  wait_osc = '0, wait_xtal = '0, wait_pll = '0;
   logic [10:0] wake_evt = '0;
   logic        busy, sleeping, done, cpu_rst, osc_req, xtal_req, pll_req;
   logic [1:0]  outcome;
   logic [10:0] wake_cause;

   always #4 clk = ~clk;

   slp_wake_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .start(start),
      .deep_sel(deep_sel), .wake_en(wake_en), .reject_en(reject_en),
      .timer_target(timer_target), .wait_osc(wait_osc), .wait_xtal(wait_xtal),
      .wait_pll(wait_pll), .wake_evt(wake_evt), .busy(busy), .sleeping(sleeping),
      .done(done), .outcome(outcome), .wake_cause(wake_cause), .cpu_rst(cpu_rst),
      .osc_req(osc_req), .xtal_req(xtal_req), .pll_req(pll_req)
   );

   typedef struct {
      int st; int cause; int rst; int slept;
      int sleep_t; int dly; int s8; int sx; int sp;
   } exp_t;

   exp_t q[$];
   int   errs = 0;
   int   checks = 0;
   int   m_sleep = 0, m_slept = 0, m_dly = 0, m_s8 = 0, m_sx = 0, m_sp = 0, m_rst = 0;

   function automatic void chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endfunction

   function automatic exp_t mk(int st, int cause, int rst, int slept, int sleep_t,
                               int dly, int s8, int sx, int sp);
      exp_t e;
      e.st = st; e.cause = cause; e.rst = rst; e.slept = slept; e.sleep_t = sleep_t;
      e.dly = dly; e.s8 = s8; e.sx = sx; e.sp = sp;
      return e;
   endfunction

   // slow tick: one cycle high out of every four
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         m_sleep = 0; m_slept = 0; m_dly = 0; m_s8 = 0; m_sx = 0; m_sp = 0; m_rst = 0;
      end else begin
         if (sleeping) begin
            m_slept = 1;
            if (slow_tick) m_sleep++;
            m_dly = 0; m_s8 = 0; m_sx = 0; m_sp = 0;
         end
         if (busy && !sleeping && !osc_req && slow_tick) m_dly++;
         if (busy && osc_req && !xtal_req) m_s8++;
         if (busy && xtal_req && !pll_req) m_sx++;
         if (busy && pll_req) m_sp++;
         if (cpu_rst) m_rst++;
         if (done) begin
            if (q.size() == 0) begin
               chk("R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk("R10", "outcome", int'(outcome), e.st);
               chk("R4", "wake_cause", int'(wake_cause), e.cause);
               chk("R10", "cpu_rst pulses", m_rst, e.rst);
               chk("R2", "entered sleep", m_slept, e.slept);
               if (e.sleep_t >= 0) chk("R6", "sleep ticks", m_sleep, e.sleep_t);
               if (e.dly >= 0) chk("R7", "wake delay ticks", m_dly, e.dly);
               if (e.s8 >= 0)  chk("R8", "osc stage cycles", m_s8, e.s8);
               if (e.sx >= 0)  chk("R8", "xtal stage cycles", m_sx, e.sx);
               if (e.sp >= 0)  chk("R8", "pll stage cycles", m_sp, e.sp);
            end
            m_sleep = 0; m_slept = 0; m_dly = 0; m_s8 = 0; m_sx = 0; m_sp = 0; m_rst = 0;
         end
      end
   end

   task automatic run(input bit deep, input logic [10:0] wen, input logic [10:0] rej,
                      input logic [31:0] tgt, input logic [7:0] w8, input logic [7:0] wx,
                      input logic [7:0] wp, input logic [10:0] pre_evt,
                      input logic [10:0] late_evt, input bit poke, input exp_t e);
      q.push_back(e);
      @(negedge clk);
      deep_sel = deep; wake_en = wen; reject_en = rej; timer_target = tgt;
      wait_osc = w8; wait_xtal = wx; wait_pll = wp; wake_evt = pre_evt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R12", "outcome cleared by start", int'(outcome), 0);
      chk("R12", "cause cleared by start", int'(wake_cause), 0);
      if (late_evt != '0 || poke) begin
         while (!sleeping) @(negedge clk);
         if (poke) begin
            // R11: second start while busy with a different configuration
            deep_sel = 1'b1; wake_en = 11'h004; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         repeat (10) @(negedge clk);
         wake_evt = wake_evt | late_evt;
      end
      while (!done) @(negedge clk);
      wake_evt = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "sleeping after reset", int'(sleeping), 0);
      chk("R1", "outcome after reset", int'(outcome), 0);
      chk("R1", "cause after reset", int'(wake_cause), 0);
      chk("R1", "cpu_rst after reset", int'(cpu_rst), 0);
      chk("R1", "requests after reset", int'({osc_req, xtal_req, pll_req}), 7);

      // R4 R7 R8 R10: light sleep, EXT0 event
      run(0, 11'h001, 11'h000, 32'd0, 8'd3, 8'd4, 8'd5, 11'h000, 11'h001, 0,
          mk(1, 1, 0, 1, -1, 7, 4, 5, 6));
      // R5 R10: deep sleep, GPIO held but ignored, EXT0 wakes
      run(1, 11'h005, 11'h000, 32'd0, 8'd2, 8'd2, 8'd2, 11'h004, 11'h001, 0,
          mk(3, 1, 1, 1, -1, 7, 3, 3, 3));
      // R5: light sleep honours GPIO
      run(0, 11'h004, 11'h000, 32'd0, 8'd1, 8'd1, 8'd1, 11'h000, 11'h004, 0,
          mk(1, 4, 0, 1, -1, 7, 2, 2, 2));
      // R2: SDIO rejects
      run(0, 11'h010, 11'h010, 32'd0, 8'd1, 8'd1, 8'd1, 11'h010, 11'h000, 0,
          mk(2, 0, 0, 0, -1, -1, -1, -1, -1));
      // R2: GPIO rejects a deep request
      run(1, 11'h001, 11'h004, 32'd0, 8'd1, 8'd1, 8'd1, 11'h004, 11'h000, 0,
          mk(2, 0, 0, 0, -1, -1, -1, -1, -1));
      // R3: other reject bits masked, EXT1 wakes at once
      run(0, 11'h002, 11'h7EB, 32'd0, 8'd1, 8'd1, 8'd1, 11'h002, 11'h000, 0,
          mk(1, 2, 0, 1, -1, 7, 2, 2, 2));
      // R6 R9: short timer raised to 128, default oscillator wait
      run(0, 11'h008, 11'h000, 32'd5, 8'd0, 8'd0, 8'd0, 11'h000, 11'h000, 0,
          mk(1, 8, 0, 1, 128, 7, 21, 1, 1));
      // R6 R10: deep timer of 200 ticks
      run(1, 11'h008, 11'h000, 32'd200, 8'd1, 8'd2, 8'd3, 11'h000, 11'h000, 0,
          mk(3, 8, 1, 1, 200, 7, 2, 3, 4));

      // R12: outcome and cause held while idle
      repeat (40) @(negedge clk);
      chk("R12", "outcome held", int'(outcome), 3);
      chk("R12", "cause held", int'(wake_cause), 8);

      // R11: start during sleep ignored; still light, EXT0 only
      run(0, 11'h001, 11'h000, 32'd0, 8'd1, 8'd1, 8'd1, 11'h000, 11'h005, 1,
          mk(1, 1, 0, 1, -1, 7, 2, 2, 2));

      repeat (5) @(negedge clk);
      chk("R10", "all expected outcomes seen", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule